// File: doc/BRIEF.md
# Audio Master-Clock Ratio Detector and Frame Resynchronizer

This block sits at the front of a stereo audio sample path and runs entirely on the master clock. It works out whether the master clock is 256 or 384 times the sample rate by timing the word clock's rising edges. It also keeps an internal frame position counter that advances on bit-clock rising edges, 64 per frame. At every word-clock rising edge it compares that counter with the frame start. A small phase error is tolerated. A larger one makes the block restart the counter at the word-clock edge and mute the sample output to midscale until alignment is confirmed.

After the power-good input rises, the block holds the output muted for a fixed initialization window. It also mutes whenever no valid ratio is locked. Downstream logic takes `sampleStrobe` as the frame-aligned load pulse and `sampleOut` as the sample it should use. `sampleOut` is either the sample captured at the last frame start or the midscale code 0x0000 while muted.

Top module: `clkratio_resync`

## Requirements
- R1: A word-clock period is the number of master-clock cycles between two rising edges. It is classed as low ratio when within 256±2 and as high ratio when within 384±2. When two consecutive periods fall in the same class, `locked` goes to 1 and `ratioIs384` takes the class (0 = 256, 1 = 384). `ratioIs384` changes only in a cycle in which `locked` is 1.
- R2: A period that fits neither class clears `locked`, and so does a valid period whose class differs from the previous period's class. The first word-clock edge after reset gives no period. While `locked` is 0, `mute` is 1.
- R3: If no word-clock rising edge arrives for 1023 master-clock cycles, `locked` clears within a few further cycles.
- R4: At each word-clock rising edge the frame position (bit-clock rising edges counted modulo 64 since the last frame start) is compared with 0. The error is the shorter way round the 64-position circle. An error of up to 6 bit-clock periods causes no realignment and no mute.
- R5: An error above 6 restarts the frame position at that word-clock edge, which counts as a frame start, and sets `mute`. `mute` stays set until a later word-clock edge finds an error within tolerance.
- R6: For the first 1024 master-clock cycles after `pwrGood` rises, `mute` is 1 whatever the lock state.
- R7: `sampleOut` is 0x0000 in every cycle in which `mute` is 1. It is forced to zero on the same clock edge that sets `mute`.
- R8: `sampleStrobe` is a one-cycle pulse at each frame start, which is a wrap of the frame position or a realignment. When not muted, `sampleOut` loads `sampleIn` on that edge and otherwise holds its value, giving exactly one strobe per frame under a steady aligned stream.
- R9: While `pwrGood` is 0: `locked`=0, `mute`=1, `ratioIs384`=0, `sampleStrobe`=0, `sampleOut`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state is clocked on its rising edge |
| pwrGood | input | 1 | Asynchronous reset, active low (power good) |
| bclkIn | input | 1 | Bit clock, synchronized internally |
| lrIn | input | 1 | Word (left/right) clock, synchronized internally |
| sampleIn | input | 16 | Signed sample offered for the current frame |
| ratioIs384 | output | 1 | Detected ratio: 0 = 256x, 1 = 384x |
| sampleStrobe | output | 1 | One-cycle frame-start pulse |
| locked | output | 1 | Ratio confirmed by two matching periods |
| mute | output | 1 | Output forced to midscale |
| sampleOut | output | 16 | Frame sample, or 0x0000 while muted |

## Verification
The assertions check on every cycle that a muted output reads zero and that an unlocked block stays muted. They also check that the output holds between strobes when unmuted and that the first 1024 cycles are muted. Further cycle checks cover a ratio change happening only while locked, lock rising only just after a word-clock edge, and lock falling after a long silence. Only the bench's scenarios can show which periods count as valid at the ±2 boundaries and the lock sequence through ratio changes. They are also needed for the split between tolerated and realigned phase errors, accumulated over randomly dropped bit-clock pulses, and for the one-strobe-per-frame capture.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_LOW  = 2'd1,
    CLS_HIGH = 2'd2
  } ratioClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic resync;
    logic muteNext;
  } ctrlStrobe_t;

  // single-bit status from datapath to control
  typedef struct packed {
    logic lrRise;
    logic periodSat;
    logic initActive;
  } dpStatus_t;
endpackage

// File: rtl/clkratio_datapath.sv
module clkratio_datapath
  import clkratio_pkg::*;
#(
  parameter int FRAME_BITS  = 64,
  parameter int INIT_CYCLES = 1024,
  parameter int CNT_W       = 10,
  parameter int BIT_W       = 6,
  parameter int SAMPLE_W    = 16
) (
  input  logic                mclk,
  input  logic                pwrGood,
  input  logic                bclkIn,
  input  logic                lrIn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  ctrlStrobe_t         ctl,
  output dpStatus_t           st,
  output logic [CNT_W-1:0]    periodCnt,
  output logic [BIT_W-1:0]    bitPos,
  output logic                sampleStrobe,
  output logic [SAMPLE_W-1:0] sampleOut
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [2:0] lrPipe;
  logic [2:0] bclkPipe;
  logic [INIT_W-1:0] initCnt;
  logic bclkRise;
  logic wrap;
  logic frameStart;

  // two synchronizer stages plus one history stage per input
  always_ff @(posedge mclk or negedge pwrGood) begin
    if (!pwrGood) begin
      lrPipe   <= '0;
      bclkPipe <= '0;
    end else begin
      lrPipe   <= {lrPipe[1:0], lrIn};
      bclkPipe <= {bclkPipe[1:0], bclkIn};
    end
  end

  assign st.lrRise     = lrPipe[1] & ~lrPipe[2];
  assign bclkRise      = bclkPipe[1] & ~bclkPipe[2];
  assign st.periodSat  = (periodCnt == CNT_MAX);
  assign st.initActive = (initCnt < INIT_W'(INIT_CYCLES));
  assign wrap          = bclkRise && (bitPos == LAST_BIT);
  assign frameStart    = ctl.resync | wrap;

  always_ff @(posedge mclk or negedge pwrGood) begin
    if (!pwrGood) begin
      periodCnt <= '0;
      initCnt   <= '0;
    end else begin
      if (st.lrRise)         periodCnt <= '0;
      else if (!st.periodSat) periodCnt <= periodCnt + 1'b1;
      if (st.initActive)     initCnt <= initCnt + 1'b1;
    end
  end

  always_ff @(posedge mclk or negedge pwrGood) begin
    if (!pwrGood) begin
      bitPos       <= '0;
      sampleStrobe <= 1'b0;
      sampleOut    <= '0;
    end else begin
      if (ctl.resync)    bitPos <= '0;
      else if (bclkRise) bitPos <= wrap ? '0 : bitPos + 1'b1;
      sampleStrobe <= frameStart;
      if (ctl.muteNext)  sampleOut <= '0;
      else if (frameStart) sampleOut <= sampleIn;
    end
  end
endmodule

// File: rtl/clkratio_control.sv
module clkratio_control
  import clkratio_pkg::*;
#(
  parameter int RATIO_LOW  = 256,
  parameter int RATIO_HIGH = 384,
  parameter int RATIO_TOL  = 2,
  parameter int FRAME_BITS = 64,
  parameter int PHASE_TOL  = 6,
  parameter int CNT_W      = 10,
  parameter int BIT_W      = 6
) (
  input  logic             mclk,
  input  logic             pwrGood,
  input  dpStatus_t        st,
  input  logic [CNT_W-1:0] periodCnt,
  input  logic [BIT_W-1:0] bitPos,
  output ctrlStrobe_t      ctl,
  output logic             ratioIs384,
  output logic             locked,
  output logic             mute
);
  timeunit 1ns;
  timeprecision 1ps;

  ratioClass_e lastCls, lastNext, clsSeen, clsNow;
  logic firstSeen;
  logic resyncMute, resyncMuteNext;
  logic lockedNext, ratioNext;
  logic overTol;
  int   measured, posInt, phaseErr;

  always_comb begin
    measured = int'(periodCnt) + 1;
    if (measured >= RATIO_LOW - RATIO_TOL && measured <= RATIO_LOW + RATIO_TOL)
      clsNow = CLS_LOW;
    else if (measured >= RATIO_HIGH - RATIO_TOL && measured <= RATIO_HIGH + RATIO_TOL)
      clsNow = CLS_HIGH;
    else
      clsNow = CLS_NONE;
    posInt   = int'(bitPos);
    phaseErr = (posInt <= FRAME_BITS / 2) ? posInt : FRAME_BITS - posInt;
    overTol  = phaseErr > PHASE_TOL;
  end

  always_comb begin
    lockedNext     = locked;
    ratioNext      = ratioIs384;
    resyncMuteNext = resyncMute;
    lastNext       = lastCls;
    clsSeen        = firstSeen ? clsNow : CLS_NONE;
    ctl.resync     = 1'b0;
    if (st.lrRise) begin
      lastNext = clsSeen;
      if (clsSeen == CLS_NONE || clsSeen != lastCls) begin
        lockedNext = 1'b0;
      end else begin
        lockedNext = 1'b1;
        ratioNext  = (clsSeen == CLS_HIGH);
      end
      ctl.resync     = overTol;
      resyncMuteNext = overTol;
    end else if (st.periodSat) begin
      lockedNext = 1'b0;
      lastNext   = CLS_NONE;
    end
    ctl.muteNext = st.initActive | ~lockedNext | resyncMuteNext;
  end

  always_ff @(posedge mclk or negedge pwrGood) begin
    if (!pwrGood) begin
      lastCls    <= CLS_NONE;
      firstSeen  <= 1'b0;
      locked     <= 1'b0;
      ratioIs384 <= 1'b0;
      resyncMute <= 1'b0;
      mute       <= 1'b1;
    end else begin
      lastCls    <= lastNext;
      if (st.lrRise) firstSeen <= 1'b1;
      locked     <= lockedNext;
      ratioIs384 <= ratioNext;
      resyncMute <= resyncMuteNext;
      mute       <= ctl.muteNext;
    end
  end
endmodule

// File: rtl/clkratio_resync.sv
module clkratio_resync
  import clkratio_pkg::*;
#(
  parameter int RATIO_LOW   = 256,
  parameter int RATIO_HIGH  = 384,
  parameter int RATIO_TOL   = 2,
  parameter int FRAME_BITS  = 64,
  parameter int PHASE_TOL   = 6,
  parameter int INIT_CYCLES = 1024,
  parameter int SAMPLE_W    = 16
) (
  input  logic                mclk,
  input  logic                pwrGood,
  input  logic                bclkIn,
  input  logic                lrIn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                ratioIs384,
  output logic                sampleStrobe,
  output logic                locked,
  output logic                mute,
  output logic [SAMPLE_W-1:0] sampleOut
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = $clog2(2 * RATIO_HIGH);
  localparam int BIT_W = $clog2(FRAME_BITS);

  ctrlStrobe_t      ctl;
  dpStatus_t        st;
  logic [CNT_W-1:0] periodCnt;
  logic [BIT_W-1:0] bitPos;

  clkratio_datapath #(
    .FRAME_BITS(FRAME_BITS), .INIT_CYCLES(INIT_CYCLES),
    .CNT_W(CNT_W), .BIT_W(BIT_W), .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .mclk(mclk), .pwrGood(pwrGood), .bclkIn(bclkIn), .lrIn(lrIn),
    .sampleIn(sampleIn), .ctl(ctl), .st(st), .periodCnt(periodCnt),
    .bitPos(bitPos), .sampleStrobe(sampleStrobe), .sampleOut(sampleOut)
  );

  clkratio_control #(
    .RATIO_LOW(RATIO_LOW), .RATIO_HIGH(RATIO_HIGH), .RATIO_TOL(RATIO_TOL),
    .FRAME_BITS(FRAME_BITS), .PHASE_TOL(PHASE_TOL),
    .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) u_ctl (
    .mclk(mclk), .pwrGood(pwrGood), .st(st), .periodCnt(periodCnt),
    .bitPos(bitPos), .ctl(ctl), .ratioIs384(ratioIs384),
    .locked(locked), .mute(mute)
  );
endmodule

// File: rtl/clkratio_checker.sv
module clkratio_checker #(
  parameter int INIT_CYCLES = 1024,
  parameter int SAT_LIMIT   = 1023,
  parameter int SAMPLE_W    = 16
) (
  input logic                mclk,
  input logic                pwrGood,
  input logic                lrIn,
  input logic                locked,
  input logic                mute,
  input logic                ratioIs384,
  input logic                sampleStrobe,
  input logic [SAMPLE_W-1:0] sampleOut
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SINCE_W = $clog2(SAT_LIMIT + INIT_CYCLES + 16);
  localparam logic [SINCE_W-1:0] SINCE_MAX = {SINCE_W{1'b1}};

  logic [SINCE_W-1:0] sinceRst;
  logic [SINCE_W-1:0] sinceLr;
  logic               lrPrev;

  always_ff @(posedge mclk or negedge pwrGood) begin
    if (!pwrGood) begin
      sinceRst <= '0;
      sinceLr  <= '0;
      lrPrev   <= 1'b0;
    end else begin
      lrPrev <= lrIn;
      if (sinceRst != SINCE_MAX) sinceRst <= sinceRst + 1'b1;
      if (lrIn && !lrPrev)       sinceLr  <= '0;
      else if (sinceLr != SINCE_MAX) sinceLr <= sinceLr + 1'b1;
    end
  end

  assert_ratio_locked_R1: assert property (@(posedge mclk) disable iff (!pwrGood)
    !$stable(ratioIs384) |-> locked);
  assert_lock_after_edge_R1: assert property (@(posedge mclk) disable iff (!pwrGood)
    $rose(locked) |-> (sinceLr <= SINCE_W'(3)));
  assert_unlocked_mute_R2: assert property (@(posedge mclk) disable iff (!pwrGood)
    !locked |-> mute);
  assert_timeout_R3: assert property (@(posedge mclk) disable iff (!pwrGood)
    (int'(sinceLr) >= SAT_LIMIT + 5) |-> !locked);
  assert_init_mute_R6: assert property (@(posedge mclk) disable iff (!pwrGood)
    (int'(sinceRst) < INIT_CYCLES) |-> mute);
  assert_mute_zero_R7: assert property (@(posedge mclk) disable iff (!pwrGood)
    mute |-> (sampleOut == '0));
  assert_hold_between_R8: assert property (@(posedge mclk) disable iff (!pwrGood)
    (!sampleStrobe && !mute) |-> $stable(sampleOut));
endmodule

bind clkratio_resync clkratio_checker #(
  .INIT_CYCLES(INIT_CYCLES), .SAT_LIMIT(2 ** CNT_W - 1), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .mclk(mclk), .pwrGood(pwrGood), .lrIn(lrIn), .locked(locked), .mute(mute),
  .ratioIs384(ratioIs384), .sampleStrobe(sampleStrobe), .sampleOut(sampleOut)
);

// File: tb/clkratio_resync_bench.sv
module clkratio_resync_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        mclk = 1'b0;
  logic        pwrGood;
  logic        bclkIn, lrIn;
  logic [15:0] sampleIn;
  logic        ratioIs384, sampleStrobe, locked, mute;
  logic [15:0] sampleOut;

  int testsRun = 0, testsFailed = 0, muteBad = 0, strobeCnt = 0;
  int genR = 256, genD = 4, reqR = 256, reqD = 4, p = 0, dropK = 0;
  int off = 0;
  bit lrEn = 1'b1;
  bit finished = 1'b0;

  always #2 mclk = ~mclk;

  clkratio_resync u_clkratio_resync (
    .mclk(mclk), .pwrGood(pwrGood), .bclkIn(bclkIn), .lrIn(lrIn),
    .sampleIn(sampleIn), .ratioIs384(ratioIs384), .sampleStrobe(sampleStrobe),
    .locked(locked), .mute(mute), .sampleOut(sampleOut)
  );

  // stream generator: word clock rises at p == genR/2, bit clock every genD cycles
  initial begin
    bclkIn = 1'b0;
    lrIn   = 1'b0;
    forever begin
      @(negedge mclk);
      if (p >= genR - 1) begin
        p = 0; genR = reqR; genD = reqD;
      end else p++;
      lrIn   = lrEn && (p >= genR / 2);
      bclkIn = ((p % genD) >= genD / 2) && !((p / genD) < dropK);
    end
  end

  function automatic int phaseErr(int o);
    int m = o % 64;
    return (m <= 32) ? m : 64 - m;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic stepCycle();
    @(negedge mclk);
    #1;
    if (sampleStrobe) strobeCnt++;
    if (mute && sampleOut != 16'h0000) muteBad++;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) stepCycle();
  endtask

  task automatic waitPhase(input int ph);
    do stepCycle(); while (p != ph);
  endtask

  task automatic switchRatio(input int r, input int d);
    reqR = r; reqD = d;
    do stepCycle(); while (genR != r);
  endtask

  // one frame with k dropped bit-clock pulses before the next word-clock edge
  task automatic frameStep(input int k);
    bit expMute;
    dropK = k;
    waitPhase(genR / 2 + 40);
    off += k;
    expMute = phaseErr(off) > 6;
    if (expMute) off = 0;
    check(mute == expMute, expMute ? "R5" : "R4", "mute after word-clock edge",
          int'(mute), int'(expMute));
    check(locked == 1'b1, "R4", "lock kept during phase errors", int'(locked), 1);
  endtask

  initial begin
    logic [15:0] v1, v2;
    void'($urandom(32'd2024));
    pwrGood  = 1'b0;
    sampleIn = 16'h0;
    waitCycles(6);
    check(locked == 0, "R9", "locked in reset", int'(locked), 0);
    check(mute == 1, "R9", "mute in reset", int'(mute), 1);
    check(ratioIs384 == 0 && sampleStrobe == 0, "R9", "ratio/strobe in reset",
          int'({ratioIs384, sampleStrobe}), 0);
    check(sampleOut == 0, "R9", "sampleOut in reset", int'(sampleOut), 0);
    pwrGood = 1'b1;

    waitCycles(900);
    check(locked == 1, "R1", "lock on 256 stream", int'(locked), 1);
    check(ratioIs384 == 0, "R1", "ratio 256", int'(ratioIs384), 0);
    check(mute == 1, "R6", "mute inside init window (900)", int'(mute), 1);
    waitCycles(115);
    check(mute == 1, "R6", "mute inside init window (1015)", int'(mute), 1);
    waitCycles(25);
    check(mute == 0, "R6", "mute released after init", int'(mute), 0);

    // frame capture and strobe rate (R8)
    waitPhase(10);
    v1 = 16'($urandom);
    sampleIn = v1;
    waitPhase(168);
    check(sampleOut == v1, "R8", "sample loaded at frame start", int'(sampleOut), int'(v1));
    v2 = ~v1;
    sampleIn = v2;
    waitPhase(228);
    check(sampleOut == v1, "R8", "sample held between strobes", int'(sampleOut), int'(v1));
    strobeCnt = 0;
    repeat (8) waitPhase(168);
    check(strobeCnt == 8, "R8", "strobes over 8 aligned frames", strobeCnt, 8);

    // phase tolerance, directed then random drops
    off = 0;
    frameStep(6);
    frameStep(1);
    frameStep(0);
    for (int i = 0; i < 40; i++) frameStep(int'($urandom % 4));
    dropK = 0;

    // switch to 384x: transition period invalid, then two matching periods
    switchRatio(384, 6);
    waitPhase(232);
    check(locked == 0, "R2", "unlocked after irregular period", int'(locked), 0);
    waitPhase(232);
    check(locked == 0 && mute == 1, "R2", "unmatched first 384 period",
          int'({locked, mute}), 1);
    waitPhase(232);
    check(locked == 1 && ratioIs384 == 1, "R1", "lock at 384", int'({locked, ratioIs384}), 3);

    switchRatio(320, 5);
    repeat (3) waitPhase(200);
    check(locked == 0 && mute == 1, "R2", "320 fits no ratio", int'({locked, mute}), 1);

    switchRatio(386, 6);
    repeat (3) waitPhase(233);
    check(locked == 1 && ratioIs384 == 1, "R1", "386 within +2", int'({locked, ratioIs384}), 3);

    switchRatio(387, 6);
    repeat (2) waitPhase(233);
    check(locked == 0, "R2", "387 outside tolerance", int'(locked), 0);

    switchRatio(254, 4);
    repeat (3) waitPhase(167);
    check(locked == 1 && ratioIs384 == 0, "R1", "254 within -2", int'({locked, ratioIs384}), 2);

    lrEn = 1'b0;
    waitCycles(1100);
    check(locked == 0 && mute == 1, "R3", "no word clock edges", int'({locked, mute}), 1);
    lrEn = 1'b1;

    check(muteBad == 0, "R7", "cycles with mute but nonzero sampleOut", muteBad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge mclk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule